// File: doc/BRIEF.md
# Shift-State Round Mixer with Word Signature

This block applies the linear portion of one round of a thirty-word shift-state hash to its internal state each time a 32-bit message word is presented. An accepted word first goes through an input-injection step. The step writes the word into the state and folds it, and one state word, into three other positions. After that the block runs a configurable number of sub-rounds. Each sub-round is a right rotation by three word positions, then a column mix, then a hook where the nonlinear substitution stage would sit. The hook passes words through unchanged. The whole update takes one clock.

Alongside the state the block keeps a 32-bit word-wide XOR signature. The injection step changes the XOR of all words by exactly one pre-update word, which is word 24. The rotations and column mixes leave that XOR unchanged. The next signature can therefore be predicted cheaply as the old signature XOR old word 24. On every accepted word the block compares this prediction against the XOR of the freshly computed state. It registers a fault flag in the same clock as the new state.

Top module: `fugue_lin_round`

## Requirements
- R1: A synchronous active-high reset clears all thirty state words, the signature and the fault flag to zero at the next clock edge.
- R2: While `msg_valid` is low, the state, signature and fault flag keep their values whatever `msg_word` carries.
- R3: On an accepted word the injection step runs its substitutions in this order:
  - word 10 ^= word 0, using the old word 0;
  - word 0 = the message;
  - word 8 ^= the message;
  - word 1 ^= word 24.
- R4: Each sub-round first rotates the state right by three positions: word i moves to position (i+3) mod 30.
- R5: Each rotation is followed by a column mix. Using the pre-mix words 4, 5 and 6, it applies word 0 ^= w4, word 1 ^= w5, word 2 ^= w6, word 15 ^= w4, word 16 ^= w5 and word 17 ^= w6.
- R6: The number of sub-rounds is the parameter `N_SUB` (default 2, allowed 1 to 4). Each sub-round ends with a substitution hook that passes all words through unchanged.
- R7: After an accepted word the signature output equals the previous signature XOR the previous word 24.
- R8: The fault flag is registered together with the new state. It is 1 when the XOR of all new state words differs from the predicted signature, and 0 otherwise. On a correct datapath it stays 0.
- R9: After an accepted word the message appears unchanged at word position 3*N_SUB, which is word 6 by default.
- R10: Words presented on consecutive clocks are each accepted, one full update per clock, with no idle cycle needed between them.
- R11: `state_out` packs word i into bits [32*i+31 : 32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Accept `msg_word` on this edge |
| msg_word | input | 32 | Message word to inject |
| state_out | output | 960 | Registered state, word i at bits [32*i +: 32] |
| sig_out | output | 32 | Registered predicted XOR signature |
| fault_out | output | 1 | Registered signature mismatch flag |

## Verification
A wrong tap, rotation distance or mix source shows up as a mismatched word in `state_out` on the clock after the very word that triggered it. Because later words keep mixing the state, the damage then spreads to more words within a few updates. A corrupted signature path shows as a wrong `sig_out` on that same clock. From then on the prediction and the actual XOR disagree, so a wrong signature is visible right away and does not fade. A datapath fault that breaks the XOR balance raises `fault_out` one clock after the offending word.

// File: rtl/fugue_lin_pkg.sv
package fugue_lin_pkg;

    localparam int WORD_W  = 32;
    localparam int N_WORDS = 30;
    localparam int ROT     = 3;
    localparam int FLAT_W  = WORD_W * N_WORDS;

    // injection taps
    localparam int TIX_ACC  = 10;
    localparam int TIX_IN   = 0;
    localparam int TIX_ECHO = 8;
    localparam int TIX_XDST = 1;
    localparam int TIX_XSRC = 24;

    // column mix: sources and the two destination bases
    localparam int CM_SRC  = 4;
    localparam int CM_DSTA = 0;
    localparam int CM_DSTB = 15;
    localparam int CM_SPAN = 3;

    typedef logic [WORD_W-1:0]  word_t;
    typedef word_t [N_WORDS-1:0] state_t;

    typedef struct packed {
        state_t st;
        word_t  pred;
    } upd_t;

    function automatic word_t xor_fold(input state_t s);
        word_t acc;
        acc = '0;
        for (int i = 0; i < N_WORDS; i++) acc ^= s[i];
        return acc;
    endfunction

    function automatic int wrap_idx(input int i);
        return i % N_WORDS;
    endfunction

endpackage

// File: rtl/fl_tix.sv
module fl_tix
    import fugue_lin_pkg::*;
(
    input  state_t s_in,
    input  word_t  msg,
    output state_t s_out
);
    always_comb begin
        s_out = s_in;
        s_out[TIX_ACC]  = s_in[TIX_ACC] ^ s_in[TIX_IN];
        s_out[TIX_IN]   = msg;
        s_out[TIX_ECHO] = s_in[TIX_ECHO] ^ msg;
        s_out[TIX_XDST] = s_in[TIX_XDST] ^ s_in[TIX_XSRC];
    end
endmodule

// File: rtl/fl_ror.sv
module fl_ror
    import fugue_lin_pkg::*;
#(
    parameter int SHIFT = ROT
) (
    input  state_t s_in,
    output state_t s_out
);
    for (genvar i = 0; i < N_WORDS; i++) begin : g_rot
        localparam int DST = (i + SHIFT) % N_WORDS;
        assign s_out[DST] = s_in[i];
    end
endmodule

// File: rtl/fl_cmix.sv
module fl_cmix
    import fugue_lin_pkg::*;
(
    input  state_t s_in,
    output state_t s_out
);
    for (genvar w = 0; w < N_WORDS; w++) begin : g_col
        if (w >= CM_DSTA && w < CM_DSTA + CM_SPAN) begin : g_a
            assign s_out[w] = s_in[w] ^ s_in[CM_SRC + (w - CM_DSTA)];
        end else if (w >= CM_DSTB && w < CM_DSTB + CM_SPAN) begin : g_b
            assign s_out[w] = s_in[w] ^ s_in[CM_SRC + (w - CM_DSTB)];
        end else begin : g_pass
            assign s_out[w] = s_in[w];
        end
    end
endmodule

// File: rtl/fl_smix_hook.sv
module fl_smix_hook
    import fugue_lin_pkg::*;
(
    input  state_t s_in,
    output state_t s_out
);
    // placeholder for the nonlinear substitution stage
    assign s_out = s_in;
endmodule

// File: rtl/fugue_lin_round.sv
module fugue_lin_round
    import fugue_lin_pkg::*;
#(
    parameter int N_SUB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [WORD_W-1:0] msg_word,
    output logic [FLAT_W-1:0] state_out,
    output logic [WORD_W-1:0] sig_out,
    output logic              fault_out
);
    state_t state_q;
    word_t  sig_q;
    logic   fault_q;

    state_t chain [N_SUB+1];
    state_t after_ror [N_SUB];
    state_t after_cm  [N_SUB];
    upd_t   nxt;
    word_t  actual_sig;

    fl_tix u_tix (
        .s_in  (state_q),
        .msg   (msg_word),
        .s_out (chain[0])
    );

    for (genvar k = 0; k < N_SUB; k++) begin : g_sub
        fl_ror #(.SHIFT(ROT)) u_ror (
            .s_in  (chain[k]),
            .s_out (after_ror[k])
        );
        fl_cmix u_cmix (
            .s_in  (after_ror[k]),
            .s_out (after_cm[k])
        );
        fl_smix_hook u_hook (
            .s_in  (after_cm[k]),
            .s_out (chain[k+1])
        );
    end

    always_comb begin
        nxt.st     = chain[N_SUB];
        nxt.pred   = sig_q ^ state_q[TIX_XSRC];
        actual_sig = xor_fold(nxt.st);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            sig_q   <= '0;
            fault_q <= 1'b0;
        end else if (msg_valid) begin
            state_q <= nxt.st;
            sig_q   <= nxt.pred;
            fault_q <= (actual_sig != nxt.pred);
        end
    end

    assign state_out = state_q;
    assign sig_out   = sig_q;
    assign fault_out = fault_q;

endmodule

// File: rtl/fugue_lin_round_chk.sv
module fugue_lin_round_chk
    import fugue_lin_pkg::*;
#(
    parameter int N_SUB = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic [WORD_W-1:0] msg_word,
    input logic [FLAT_W-1:0] state_out,
    input logic [WORD_W-1:0] sig_out,
    input logic              fault_out
);
    localparam int MPOS = (ROT * N_SUB) % N_WORDS;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_out == '0 && sig_out == '0 && !fault_out));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> ($stable(state_out) && $stable(sig_out) && $stable(fault_out)));

    p_sig_predict_r7: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> sig_out == ($past(sig_out) ^ $past(state_out[TIX_XSRC*WORD_W +: WORD_W])));

    p_sig_matches_state_r8: assert property (@(posedge clk) disable iff (rst)
        !fault_out |-> sig_out == xor_fold(state_t'(state_out)));

    if (N_SUB >= 1 && N_SUB <= 4) begin : g_mpos
        p_msg_lands_r9: assert property (@(posedge clk) disable iff (rst)
            msg_valid |=> state_out[MPOS*WORD_W +: WORD_W] == $past(msg_word));
    end

    p_param_r6: assert final (N_SUB >= 1 && N_SUB <= 4);

endmodule

bind fugue_lin_round fugue_lin_round_chk #(.N_SUB(N_SUB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_word  (msg_word),
    .state_out (state_out),
    .sig_out   (sig_out),
    .fault_out (fault_out)
);

// File: tb/fugue_lin_round_test.sv
module fugue_lin_round_test;
    localparam int NW    = 30;
    localparam int WW    = 32;
    localparam int NSUB  = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           msg_valid = 1'b0;
    logic [WW-1:0]  msg_word = '0;
    logic [NW*WW-1:0] state_out;
    logic [WW-1:0]  sig_out;
    logic           fault_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [WW-1:0] mdl [NW];
    logic [WW-1:0] mdl_sig;

    always #4 clk = ~clk;

    fugue_lin_round #(.N_SUB(NSUB)) uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_word(msg_word),
        .state_out(state_out), .sig_out(sig_out), .fault_out(fault_out)
    );

    function automatic logic [WW-1:0] dut_word(input int i);
        return state_out[i*WW +: WW];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NW; i++) mdl[i] = '0;
        mdl_sig = '0;
    endtask

    task automatic model_step(input logic [WW-1:0] m);
        logic [WW-1:0] t [NW];
        logic [WW-1:0] r [NW];
        logic [WW-1:0] a, b, c;
        mdl_sig = mdl_sig ^ mdl[24];
        for (int i = 0; i < NW; i++) t[i] = mdl[i];
        t[10] = t[10] ^ t[0];
        t[0]  = m;
        t[8]  = t[8] ^ m;
        t[1]  = t[1] ^ t[24];
        for (int s = 0; s < NSUB; s++) begin
            for (int i = 0; i < NW; i++) r[(i + 3) % NW] = t[i];
            a = r[4]; b = r[5]; c = r[6];
            r[0] ^= a; r[1] ^= b; r[2] ^= c;
            r[15] ^= a; r[16] ^= b; r[17] ^= c;
            for (int i = 0; i < NW; i++) t[i] = r[i];
        end
        for (int i = 0; i < NW; i++) mdl[i] = t[i];
    endtask

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [WW-1:0] last_msg, input bit check_pos);
        int bad;
        bad = -1;
        for (int i = 0; i < NW; i++) if (dut_word(i) !== mdl[i] && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, tag, '0, '0);
        else chk(1'b0, {tag, " state word (R3 R4 R5 R6 R11)"}, dut_word(bad), mdl[bad]);
        chk(sig_out === mdl_sig, "R7 signature", sig_out, mdl_sig);
        chk(fault_out === 1'b0, "R8 fault flag", {31'd0, fault_out}, '0);
        if (check_pos)
            chk(dut_word(3 * NSUB) === last_msg, "R9 message position", dut_word(3 * NSUB), last_msg);
    endtask

    // one accepted word, sampled on the following falling edge
    task automatic push(input logic [WW-1:0] m, input string tag);
        msg_valid = 1'b1;
        msg_word  = m;
        @(posedge clk);
        model_step(m);
        @(negedge clk);
        check_all(tag, m, 1'b1);
    endtask

    task automatic idle(input logic [WW-1:0] junk);
        msg_valid = 1'b0;
        msg_word  = junk;
        @(posedge clk);
        @(negedge clk);
        check_all("R2 idle hold", '0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        msg_valid = 1'b1;
        msg_word = 32'hDEAD_BEEF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        msg_valid = 1'b0;
        model_reset();
        check_all("R1 reset", '0, 1'b0);
    endtask

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // single known word from zero state: R3 ordering
        push(32'h0000_0001, "R3 first word");
        // walking ones back to back: R10
        for (int k = 0; k < 64; k++) push(32'h1 << (k % 32), "R10 walking ones");
        // idle with changing junk: R2
        for (int k = 0; k < 8; k++) idle(32'hA5A5_0000 + k);
        // arithmetic sweep with gaps: R4 R5
        for (int k = 0; k < 240; k++) begin
            push(32'h9E37_79B9 * (k + 1) ^ (k << 7), "R4 R5 sweep");
            if (k % 3 == 2) idle(~k);
        end
        // all-ones and zero words
        push(32'hFFFF_FFFF, "R6 all ones");
        push(32'h0000_0000, "R6 zero");
        // reset mid-stream: R1
        do_reset();
        for (int k = 0; k < 40; k++) push(32'h0102_0304 + k * 32'h1111, "R11 post-reset");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule